// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the digital side of a 10-bit successive-approximation converter. A byte-wide register port holds two control registers and two result registers. Software picks an input channel, enables the analog input, and chooses single or repeat operation and a conversion length. A write with the start bit set launches a conversion. The block counts the chosen number of clocks, then captures a word from an external converter data bus. It stores that word left-justified across the two result registers, raises an end-of-conversion flag and pulses an interrupt.

The flag clears when software reads the high result byte, or when software starts a new conversion. A result already captured stays readable until the next conversion completes. A low-power request abandons any conversion in progress and clears the run state, the flags and the results. Once the request is released, nothing restarts on its own.

Top module: `adc_seq`

## Requirements
- R1: After reset all four registers read 0x00, the interrupt output is low and the analog enable output is low.
- R2: Control register 1 (address 0) holds the channel in bits [3:0], analog enable in bit 4, mode in bit 5 (1 = repeat, 0 = single) and start in bit 7. Bit 6 reads 0. The channel and enable fields drive the analog outputs directly.
- R3: Control register 2 (address 1) holds a read/write time select in bits [2:0]. A conversion lasts 39 << select clocks. The busy flag (bit 6) reads 1 from the cycle after the start write until the completing edge, which falls exactly 39 << select clocks after the start write edge.
- R4: On the completing edge, the converter data bus is captured left-justified: bits [9:2] go to the high result (address 2), and bits [1:0] go to bits [7:6] of the low result (address 3), whose other bits are 0. The end-of-conversion flag (control register 2 bit 7) is set on the same edge.
- R5: Each completion drives the interrupt output high for exactly one clock.
- R6: Reading the high result register with the read strobe clears the end-of-conversion flag. Reading the low result register leaves the flag unchanged.
- R7: A software start clears the end-of-conversion flag. The previous result stays readable until the new conversion completes.
- R8: In single mode the start bit and the busy flag return to 0 on the completing edge.
- R9: In repeat mode the start bit stays 1 and the next conversion begins on the completing edge. Writing the start bit to 0 lets the current conversion finish, and no further conversion follows.
- R10: A start write while busy does not restart or lengthen the conversion in progress.
- R11: While the low-power input is high, the following are cleared: start, mode, analog enable, end-of-conversion, busy and both results. Any conversion in progress is abandoned without an interrupt. Channel and time select are kept. No conversion begins after the input falls until software starts one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_mode_i | input | 1 | Low-power request; aborts and clears |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (read side effects) |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| conv_data_i | input | RES_W | Converter data bus, sampled on completion |
| ana_chan_o | output | CHAN_W | Selected analog channel |
| ana_en_o | output | 1 | Analog input enable |
| irq_o | output | 1 | Conversion-complete pulse |

## Verification
The bench targets the exact completion edge. A counter that is off by one would show busy dropping or the interrupt rising one clock early or late. It also starts a conversion while eoc is still set: a design that cleared the result too early, or kept the flag, would show stale data or a stale flag mid-conversion. A repeat run is stopped partway, which catches a design that aborts at once or keeps converting. A low-power pulse is applied both when idle and mid-conversion, so a design that keeps any run state, loses the channel or time select, or resumes by itself after release is caught.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int BUS_W = 8;

   typedef enum logic [1:0] {
      ADR_CTL1 = 2'd0,
      ADR_CTL2 = 2'd1,
      ADR_RESH = 2'd2,
      ADR_RESL = 2'd3
   } adc_addr_e;

   // bit positions inside the control bytes
   localparam int C1_AIN   = 4;
   localparam int C1_MODE  = 5;
   localparam int C1_START = 7;
   localparam int C2_BUSY  = 6;
   localparam int C2_EOC   = 7;
endpackage

// File: rtl/adc_seq_ctl.sv
module adc_seq_ctl #(
   parameter int CHAN_W = 4,
   parameter int TSEL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lp,
   input  logic              wr_c1,
   input  logic              wr_c2,
   input  logic [CHAN_W-1:0] w_chan,
   input  logic              w_ain,
   input  logic              w_mode,
   input  logic              w_start,
   input  logic [TSEL_W-1:0] w_tsel,
   input  logic              busy,
   input  logic              done,
   output logic [CHAN_W-1:0] chan_q,
   output logic              ain_q,
   output logic              mode_q,
   output logic              start_q,
   output logic [TSEL_W-1:0] tsel_q,
   output logic              start_go
);
   assign start_go = wr_c1 && w_start && !busy && !lp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_q  <= '0;
         ain_q   <= 1'b0;
         mode_q  <= 1'b0;
         start_q <= 1'b0;
         tsel_q  <= '0;
      end else if (lp) begin
         ain_q   <= 1'b0;
         mode_q  <= 1'b0;
         start_q <= 1'b0;
      end else begin
         if (done && !mode_q)
            start_q <= 1'b0;
         if (wr_c1) begin
            chan_q <= w_chan;
            ain_q  <= w_ain;
            mode_q <= w_mode;
            if (!w_start)
               start_q <= 1'b0;
            else if (!busy)
               start_q <= 1'b1;
         end
         if (wr_c2)
            tsel_q <= w_tsel;
      end
   end

   AST_SINGLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      done && !mode_q && !lp |=> !start_q) else $error("single mode kept start"); // R8
   AST_LP_CTL: assert property (@(posedge clk) disable iff (!rst_n)
      lp |=> !start_q && !mode_q && !ain_q) else $error("low power left control set"); // R11
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
   parameter int BASE_CYC = 39,
   parameter int TSEL_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lp,
   input  logic              start_go,
   input  logic              cont,
   input  logic [TSEL_W-1:0] tsel,
   output logic              busy,
   output logic              done
);
   localparam int MAX_CYC = BASE_CYC << ((1 << TSEL_W) - 1);
   localparam int CNT_W   = $clog2(MAX_CYC);

   logic [CNT_W-1:0] cnt_q, load_val;

   always_comb load_val = (CNT_W'(BASE_CYC) << tsel) - CNT_W'(1);
   assign done = busy && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (lp) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (start_go) begin
         busy  <= 1'b1;
         cnt_q <= load_val;
      end else if (done) begin
         busy  <= cont;
         cnt_q <= load_val;
      end else if (busy) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !done && !lp |=> busy) else $error("busy dropped early"); // R3
   AST_LP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      lp |=> !busy) else $error("conversion survived low power"); // R11
   AST_REPEAT_GO: assert property (@(posedge clk) disable iff (!rst_n)
      done && cont && !lp |=> busy) else $error("repeat did not restart"); // R9
endmodule

// File: rtl/adc_seq_result.sv
module adc_seq_result #(
   parameter int RES_W     = 10,
   parameter bit LEFT_JUST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lp,
   input  logic             done,
   input  logic             start_go,
   input  logic             rd_hi,
   input  logic [RES_W-1:0] conv_data,
   output logic [7:0]       res_hi,
   output logic [7:0]       res_lo,
   output logic             eoc_q,
   output logic             irq_q
);
   logic [RES_W-1:0] res_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         eoc_q <= 1'b0;
         irq_q <= 1'b0;
      end else if (lp) begin
         res_q <= '0;
         eoc_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= done;
         if (done) begin
            res_q <= conv_data;
            eoc_q <= 1'b1;
         end else if (start_go || rd_hi) begin
            eoc_q <= 1'b0;
         end
      end
   end

   generate
      if (LEFT_JUST) begin : g_left
         assign res_hi = res_q[RES_W-1 -: 8];
         assign res_lo = {res_q[RES_W-9:0], {(16-RES_W){1'b0}}};
      end else begin : g_right
         assign res_lo = res_q[7:0];
         assign res_hi = {{(16-RES_W){1'b0}}, res_q[RES_W-1:8]};
      end
   endgenerate

   AST_IRQ_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q) else $error("interrupt longer than a clock"); // R5
   AST_EOC_AT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> eoc_q) else $error("interrupt without flag"); // R4
   AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done && !lp |=> $stable(res_q)) else $error("result changed without completion"); // R7
   AST_LP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      lp |=> !eoc_q && !irq_q && res_q == '0) else $error("result kept in low power"); // R11
endmodule

// File: rtl/adc_seq.sv
module adc_seq
   import adc_seq_pkg::*;
#(
   parameter int RES_W     = 10,
   parameter int CHAN_W    = 4,
   parameter int TSEL_W    = 3,
   parameter int BASE_CYC  = 39,
   parameter bit LEFT_JUST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lp_mode_i,
   input  logic              bus_wr_i,
   input  logic              bus_rd_i,
   input  logic [1:0]        bus_addr_i,
   input  logic [7:0]        bus_wdata_i,
   output logic [7:0]        bus_rdata_o,
   input  logic [RES_W-1:0]  conv_data_i,
   output logic [CHAN_W-1:0] ana_chan_o,
   output logic              ana_en_o,
   output logic              irq_o
);
   initial begin
      assert (BASE_CYC >= 2 && BASE_CYC <= (1 << 20)) else $error("BASE_CYC out of range");
      assert (TSEL_W >= 1 && TSEL_W <= 3) else $error("TSEL_W out of range");
      assert (RES_W >= 9 && RES_W <= 15) else $error("RES_W out of range");
      assert (CHAN_W >= 1 && CHAN_W <= 4) else $error("CHAN_W out of range");
   end

   logic wr_c1, wr_c2, rd_hi;
   logic busy, done, start_go;
   logic mode_q, start_q, ain_q, eoc_q;
   logic [CHAN_W-1:0] chan_q;
   logic [TSEL_W-1:0] tsel_q;
   logic [7:0] res_hi, res_lo, c1_rd, c2_rd;
   logic wdata_unused;

   assign wdata_unused = ^bus_wdata_i;
   assign wr_c1 = bus_wr_i && (bus_addr_i == ADR_CTL1);
   assign wr_c2 = bus_wr_i && (bus_addr_i == ADR_CTL2);
   assign rd_hi = bus_rd_i && (bus_addr_i == ADR_RESH) && !lp_mode_i;

   adc_seq_ctl #(.CHAN_W(CHAN_W), .TSEL_W(TSEL_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .lp(lp_mode_i),
      .wr_c1(wr_c1), .wr_c2(wr_c2),
      .w_chan(bus_wdata_i[CHAN_W-1:0]), .w_ain(bus_wdata_i[C1_AIN]),
      .w_mode(bus_wdata_i[C1_MODE]), .w_start(bus_wdata_i[C1_START]),
      .w_tsel(bus_wdata_i[TSEL_W-1:0]),
      .busy(busy), .done(done),
      .chan_q(chan_q), .ain_q(ain_q), .mode_q(mode_q), .start_q(start_q),
      .tsel_q(tsel_q), .start_go(start_go)
   );

   adc_seq_timer #(.BASE_CYC(BASE_CYC), .TSEL_W(TSEL_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .lp(lp_mode_i),
      .start_go(start_go), .cont(start_q && mode_q), .tsel(tsel_q),
      .busy(busy), .done(done)
   );

   adc_seq_result #(.RES_W(RES_W), .LEFT_JUST(LEFT_JUST)) u_res (
      .clk(clk), .rst_n(rst_n), .lp(lp_mode_i),
      .done(done), .start_go(start_go), .rd_hi(rd_hi),
      .conv_data(conv_data_i),
      .res_hi(res_hi), .res_lo(res_lo), .eoc_q(eoc_q), .irq_q(irq_o)
   );

   always_comb begin
      c1_rd = '0;
      c1_rd[CHAN_W-1:0] = chan_q;
      c1_rd[C1_AIN]     = ain_q;
      c1_rd[C1_MODE]    = mode_q;
      c1_rd[C1_START]   = start_q;
      c2_rd = '0;
      c2_rd[TSEL_W-1:0] = tsel_q;
      c2_rd[C2_BUSY]    = busy;
      c2_rd[C2_EOC]     = eoc_q;
   end

   always_comb begin
      case (bus_addr_i)
         ADR_CTL1: bus_rdata_o = c1_rd;
         ADR_CTL2: bus_rdata_o = c2_rd;
         ADR_RESH: bus_rdata_o = res_hi;
         default:  bus_rdata_o = res_lo;
      endcase
   end

   assign ana_chan_o = chan_q;
   assign ana_en_o   = ain_q;

   AST_RD_HI_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hi && !done |=> !eoc_q) else $error("high read left flag set"); // R6
endmodule

// File: tb/test_adc_seq.sv
module test_adc_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lp = 1'b0, wr = 1'b0, rd = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic [9:0] cdata = 10'd0;
   logic [3:0] achan;
   logic aen, irq;

   int n_chk = 0, n_err = 0, cyc = 0;

   localparam int BASE = 39;
   // {tsel[2:0], chan[3:0], data[9:0]}
   localparam logic [16:0] VEC [6] = '{
      {3'd0, 4'd3,  10'h3FF},
      {3'd1, 4'd5,  10'h000},
      {3'd0, 4'd15, 10'h2AA},
      {3'd0, 4'd0,  10'h155},
      {3'd1, 4'd9,  10'h201},
      {3'd0, 4'd7,  10'h0FE}
   };

   always #5 clk = ~clk;

   adc_seq i_adc_seq (
      .clk(clk), .rst_n(rst_n), .lp_mode_i(lp),
      .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .conv_data_i(cdata), .ana_chan_o(achan), .ana_en_o(aen), .irq_o(irq)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
      addr = a; rd = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   task automatic wait_cyc(input int n, output int irqs);
      irqs = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (irq) irqs++;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_err++;
         $display("FAIL watchdog R1 cycles=%0d expected<=%0d", cyc, 150000);
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk + 1);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int k, n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         peek(2'(a), d);
         chk("R1", "reg after reset", d, 8'h00);
      end
      chk("R1", "irq after reset", irq, 0);
      chk("R1", "ana_en after reset", aen, 0);

      // R2 control register 1 layout
      wr_reg(2'd0, 8'h7A);
      peek(2'd0, d);
      chk("R2", "ctl1 readback", d, 8'h3A);
      chk("R2", "ana_chan", achan, 4'hA);
      chk("R2", "ana_en", aen, 1);
      wr_reg(2'd0, 8'h00);

      // table of single conversions: R3 R4 R5 R8
      for (int v = 0; v < 6; v++) begin
         logic [2:0] ts;
         logic [3:0] ch;
         logic [9:0] dv;
         {ts, ch, dv} = VEC[v];
         n = BASE << ts;
         cdata = dv;
         wr_reg(2'd1, {5'd0, ts});
         wr_reg(2'd0, 8'h90 | {4'd0, ch});
         peek(2'd1, d);
         chk("R3", "busy after start", d[6], 1);
         wait_cyc(n - 1, k);
         chk("R3", "no irq before end", k, 0);
         peek(2'd1, d);
         chk("R3", "busy on last cycle", d[6], 1);
         @(negedge clk);
         chk("R5", "irq at completion", irq, 1);
         peek(2'd1, d);
         chk("R4", "eoc at completion", d[7], 1);
         chk("R8", "busy cleared single", d[6], 0);
         chk("R3", "tsel readback", d[2:0], ts);
         peek(2'd2, d);
         chk("R4", "result high", d, dv[9:2]);
         peek(2'd3, d);
         chk("R4", "result low", d, {dv[1:0], 6'd0});
         peek(2'd0, d);
         chk("R8", "start cleared single", d[7], 0);
         chk("R2", "channel driven", achan, ch);
         @(negedge clk);
         chk("R5", "irq one cycle", irq, 0);
      end

      // R6 read effects
      rd_reg(2'd3, d);
      peek(2'd1, d);
      chk("R6", "low read keeps eoc", d[7], 1);
      rd_reg(2'd2, d);
      chk("R6", "high read data", d, 8'h3F);
      peek(2'd1, d);
      chk("R6", "high read clears eoc", d[7], 0);

      // R7 restart keeps old result, clears flag
      wr_reg(2'd1, 8'h00);
      cdata = 10'h3C3;
      wr_reg(2'd0, 8'h90);
      wait_cyc(BASE, k);
      peek(2'd1, d);
      chk("R7", "eoc set before restart", d[7], 1);
      cdata = 10'h111;
      wr_reg(2'd0, 8'h90);
      peek(2'd1, d);
      chk("R7", "start clears eoc", d[7], 0);
      peek(2'd2, d);
      chk("R7", "old result kept", d, 8'hF0);
      wait_cyc(BASE, k);
      chk("R7", "one irq", k, 1);
      peek(2'd2, d);
      chk("R7", "new result", d, 8'h44);

      // R10 start while busy ignored
      cdata = 10'h080;
      wr_reg(2'd0, 8'h90);
      wait_cyc(10, k);
      wr_reg(2'd0, 8'h90);
      wait_cyc(BASE - 12, k);
      chk("R10", "no early irq", k, 0);
      peek(2'd1, d);
      chk("R10", "still busy", d[6], 1);
      @(negedge clk);
      chk("R10", "completion on original edge", irq, 1);

      // R9 repeat mode
      cdata = 10'h004;
      wr_reg(2'd0, 8'hB2);
      wait_cyc(BASE, k);
      chk("R9", "first repeat irq", k, 1);
      peek(2'd0, d);
      chk("R9", "start stays in repeat", d[7], 1);
      peek(2'd1, d);
      chk("R9", "busy stays in repeat", d[6], 1);
      cdata = 10'h3F8;
      wait_cyc(BASE, k);
      chk("R9", "second repeat irq", k, 1);
      peek(2'd2, d);
      chk("R9", "second result", d, 8'hFE);
      wait_cyc(5, k);
      wr_reg(2'd0, 8'h32);
      wait_cyc(BASE - 6, k);
      chk("R9", "current run finishes", k, 1);
      peek(2'd1, d);
      chk("R9", "busy off after stop", d[6], 0);
      wait_cyc(BASE + 5, k);
      chk("R9", "no more runs", k, 0);

      // R11 low power while idle with flag set
      lp = 1'b1;
      @(negedge clk);
      lp = 1'b0;
      peek(2'd1, d);
      chk("R11", "eoc cleared", d[7], 0);
      peek(2'd2, d);
      chk("R11", "result cleared", d, 8'h00);

      // R11 low power mid-conversion
      wr_reg(2'd1, 8'h01);
      wr_reg(2'd0, 8'hB5);
      wait_cyc(20, k);
      lp = 1'b1;
      wait_cyc(3, k);
      lp = 1'b0;
      peek(2'd0, d);
      chk("R11", "ctl1 after low power", d, 8'h05);
      peek(2'd1, d);
      chk("R11", "ctl2 after low power", d, 8'h01);
      chk("R11", "analog disabled", aen, 0);
      wait_cyc(200, k);
      chk("R11", "no irq after abort", k, 0);
      peek(2'd1, d);
      chk("R11", "no restart", d[6], 0);

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule